// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller. It serves several banks of pins, each bank as wide as the 32-bit register bus. A host reads and writes the registers with simple one-cycle strobes. Registers are grouped by function. Each function takes a 16-byte slot, and inside that slot each bank has its own word at a 4-byte step. The byte address of a register is therefore `function * 0x10 + bank * 0x4`.

For each bank the controller holds:
- a direction word, which drives the pad output enables;
- an output latch, which can be changed without a read-modify-write through set-only and clear-only addresses;
- rising and falling capture enables;
- a sticky pending word, cleared by writing one.

It also provides four plain storage words: polarity, high level, low level and edge mode.

Every pin input passes through a two-flop synchroniser. The synchronised value is what the level readback returns and what the edge detector compares. A single interrupt line stays high while any pending bit in any bank is set.

Top module: `gpioEdgeCtl`

## Requirements
- R1: Function index is address bits [7:4] and bank index is bits [3:2]. The indices are 0 direction, 1 polarity, 2 level/output, 3 set, 4 clear, 5 rise enable, 6 fall enable, 7 high level, 8 low level, 9 pending, 10 edge mode. An address with function above 10, or with bank 3 or higher (bank index at or above the number of banks), or with bits [1:0] not zero, reads 0 and ignores writes.
- R2: A 1 in the direction word makes that pin an output (`pinOe` high). A 0 makes it an input. The word reads back as written.
- R3: Writing the set address ORs the written word into the bank's output latch. Writing the clear address removes the ones of the written word from it. Zero bits leave outputs unchanged. Writing function 2 loads the latch with the whole word.
- R4: Reading function 2 returns the synchronised pin levels of the bank. A pin change is visible after the second rising clock edge.
- R5: A pin with its rise-enable bit set records a 0-to-1 change of its synchronised level in its pending bit, on the third clock edge after the pin changes.
- R6: A pin with its fall-enable bit set records a 1-to-0 change in its pending bit. A change in the direction that is not enabled records nothing.
- R7: A pin with both enables set records changes in either direction.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a new capture and a clear hit the same bit in the same cycle, the bit stays set.
- R9: `irqOut` is high exactly while at least one pending bit in any bank is set.
- R10: The polarity, high-level, low-level and edge-mode words are plain read/write storage.
- R11: After reset every register is 0, so `pinOut`, `pinOe` and `irqOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W (8) | Byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe; read data valid in the same cycle |
| busWData | input | BANK_W (32) | Write data |
| busRData | output | BANK_W (32) | Read data, 0 when not reading or unmapped |
| pinIn | input | NUM_BANKS*BANK_W (96) | Asynchronous pin levels |
| pinOut | output | NUM_BANKS*BANK_W (96) | Output latch values |
| pinOe | output | NUM_BANKS*BANK_W (96) | Output enables from the direction words |
| irqOut | output | 1 | Combined pending interrupt |

## Verification
Capture is tried with a rising edge on a rise-only pin, a falling edge on a fall-only pin, the opposite edge on each of these pins, and both edges on a dual-enabled pin. Together these separate the rise path from the fall path and show that each enable is applied to its own direction. Output control is tried with set, clear, an all-zero set and a full load, which separates atomic merging from plain overwrites. A clear written in the very cycle a new edge lands shows that the capture takes priority over the clear. Reads and writes to addresses past the function range or the bank range show that the decoder rejects them.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int FUNC_W     = 4;
  localparam int BANK_SEL_W = 2;
  localparam int NUM_FUNCS  = 11;

  typedef enum logic [FUNC_W-1:0] {
    F_DIR  = 4'd0,
    F_POL  = 4'd1,
    F_LVL  = 4'd2,
    F_SET  = 4'd3,
    F_CLR  = 4'd4,
    F_RISE = 4'd5,
    F_FALL = 4'd6,
    F_HIGH = 4'd7,
    F_LOW  = 4'd8,
    F_PEND = 4'd9,
    F_EDGE = 4'd10
  } funcE;

  typedef struct packed {
    logic                  wrHit;
    logic                  rdHit;
    funcE                  func;
    logic [BANK_SEL_W-1:0] bank;
  } busStrbT;
endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output busStrbT           strb
);
  logic [FUNC_W-1:0]     funcRaw;
  logic [BANK_SEL_W-1:0] bankRaw;
  logic                  upperZero;
  logic                  mapped;

  assign funcRaw = busAddr[7:4];
  assign bankRaw = busAddr[3:2];

  generate
    if (ADDR_W > 8) begin : g_upper
      assign upperZero = ~|busAddr[ADDR_W-1:8];
    end else begin : g_noUpper
      assign upperZero = 1'b1;
    end
  endgenerate

  assign mapped = upperZero && (busAddr[1:0] == 2'b00)
               && (funcRaw < FUNC_W'(NUM_FUNCS))
               && (32'(bankRaw) < NUM_BANKS);

  always_comb begin
    strb.wrHit = busWrEn && mapped;
    strb.rdHit = busRdEn && mapped;
    strb.func  = funcE'(funcRaw);
    strb.bank  = bankRaw;
  end
endmodule

// File: rtl/gpio_bankdp.sv
module gpio_bankdp
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  localparam int PIN_W    = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrbT           strb,
  input  logic [BANK_W-1:0] wData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [BANK_W-1:0] rData,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe,
  output logic              irqOut
);
  logic [BANK_W-1:0]    rdWord [NUM_BANKS];
  logic [NUM_BANKS-1:0] pendAny;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] dirR, polR, outR, riseEn, fallEn, hiR, loR, edgR, pendR;
    logic [BANK_W-1:0] syncA, syncB, prevS;
    logic [BANK_W-1:0] evt, clrMask, word;
    logic              wrB;

    assign wrB     = strb.wrHit && (strb.bank == BANK_SEL_W'(b));
    assign evt     = (syncB & ~prevS & riseEn) | (~syncB & prevS & fallEn);
    assign clrMask = (wrB && strb.func == F_PEND) ? wData : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirR <= '0; polR <= '0; outR <= '0; riseEn <= '0; fallEn <= '0;
        hiR <= '0; loR <= '0; edgR <= '0; pendR <= '0;
        syncA <= '0; syncB <= '0; prevS <= '0;
      end else begin
        syncA <= pinIn[b*BANK_W +: BANK_W];
        syncB <= syncA;
        prevS <= syncB;
        // new capture overrides a clear in the same cycle
        pendR <= (pendR & ~clrMask) | evt;
        if (wrB) begin
          case (strb.func)
            F_DIR:  dirR   <= wData;
            F_POL:  polR   <= wData;
            F_LVL:  outR   <= wData;
            F_SET:  outR   <= outR | wData;
            F_CLR:  outR   <= outR & ~wData;
            F_RISE: riseEn <= wData;
            F_FALL: fallEn <= wData;
            F_HIGH: hiR    <= wData;
            F_LOW:  loR    <= wData;
            F_EDGE: edgR   <= wData;
            default: ;
          endcase
        end
      end
    end

    always_comb begin
      case (strb.func)
        F_DIR:   word = dirR;
        F_POL:   word = polR;
        F_LVL:   word = syncB;
        F_RISE:  word = riseEn;
        F_FALL:  word = fallEn;
        F_HIGH:  word = hiR;
        F_LOW:   word = loR;
        F_PEND:  word = pendR;
        F_EDGE:  word = edgR;
        default: word = '0;
      endcase
    end

    assign rdWord[b]                  = word;
    assign pinOut[b*BANK_W +: BANK_W] = outR;
    assign pinOe[b*BANK_W +: BANK_W]  = dirR;
    assign pendAny[b]                 = |pendR;
  end

  assign rData  = strb.rdHit ? rdWord[strb.bank] : '0;
  assign irqOut = |pendAny;
endmodule

// File: rtl/gpioEdgeCtl.sv
module gpioEdgeCtl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  localparam int PIN_W    = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BANK_W-1:0] busWData,
  output logic [BANK_W-1:0] busRData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe,
  output logic              irqOut
);
  busStrbT strb;

  gpio_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) decI (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .strb(strb)
  );

  gpio_bankdp #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .wData(busWData), .pinIn(pinIn),
    .rData(busRData), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );
endmodule

// File: rtl/gpioEdgeCtl_chk.sv
module gpioEdgeCtl_chk #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  localparam int PIN_W    = NUM_BANKS * BANK_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [BANK_W-1:0] busWData,
  input logic [BANK_W-1:0] busRData,
  input logic [PIN_W-1:0]  pinOut,
  input logic [PIN_W-1:0]  pinOe,
  input logic              irqOut
);
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == ADDR_W'(8'h00) |=> pinOe[BANK_W-1:0] == $past(busWData)); // R2

  AST_SET_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == ADDR_W'(8'h30) |=>
      pinOut[BANK_W-1:0] == ($past(pinOut[BANK_W-1:0]) | $past(busWData))); // R3

  AST_CLR_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == ADDR_W'(8'h40) |=>
      pinOut[BANK_W-1:0] == ($past(pinOut[BANK_W-1:0]) & ~$past(busWData))); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(pinOut) && $stable(pinOe)); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && busAddr[7:4] > 4'd10 |-> busRData == '0); // R1

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irqOut && !busWrEn |=> irqOut); // R9
endmodule

bind gpioEdgeCtl gpioEdgeCtl_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) chkI (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busWData(busWData), .busRData(busRData), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
);

// File: tb/gpioEdgeCtl_test.sv
module gpioEdgeCtl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic [95:0] pinIn = '0;
  logic [95:0] pinOut, pinOe;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpioEdgeCtl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWData(busWData), .busRData(busRData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqOut(irqOut)
  );

  // monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    if (busRdEn) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expectation, actual %h expected none", busRData);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (busRData !== e) begin
          errors++;
          $display("FAIL %s: addr %h actual %h expected %h", t, busAddr, busRData, e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    busAddr = a; busRdEn = 1'b1;
    expQ.push_back(e); tagQ.push_back(tag);
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic drivePins(input logic [95:0] v);
    @(posedge clk); #1;
    pinIn = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R11 reset state
    chk("R11", pinOut, '0);
    chk("R11", pinOe, '0);
    chk("R11", {95'd0, irqOut}, '0);
    rd(8'h00, 32'h0, "R11");

    // R2 direction
    wr(8'h04, 32'hF0F0_0001);
    chk("R2", pinOe, {32'h0, 32'hF0F0_0001, 32'h0});
    rd(8'h04, 32'hF0F0_0001, "R2");

    // R3 atomic set/clear and full load
    wr(8'h30, 32'h0000_00FF);
    chk("R3", pinOut[31:0], 96'h0000_00FF);
    wr(8'h40, 32'h0000_000F);
    chk("R3", pinOut[31:0], 96'h0000_00F0);
    wr(8'h30, 32'h0);
    chk("R3", pinOut[31:0], 96'h0000_00F0);
    wr(8'h28, 32'h0000_1234);
    chk("R3", pinOut, {32'h0000_1234, 32'h0, 32'h0000_00F0});

    // R10 plain storage
    wr(8'h18, 32'hA5A5_A5A5); rd(8'h18, 32'hA5A5_A5A5, "R10");
    wr(8'h70, 32'h1111_2222); rd(8'h70, 32'h1111_2222, "R10");
    wr(8'h84, 32'h3333_4444); rd(8'h84, 32'h3333_4444, "R10");
    wr(8'hA8, 32'h5555_6666); rd(8'hA8, 32'h5555_6666, "R10");

    // R1 unmapped
    rd(8'hB0, 32'h0, "R1");
    rd(8'hF0, 32'h0, "R1");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R1");
    chk("R1", pinOe, {32'h0, 32'hF0F0_0001, 32'h0});

    // R4 level readback
    drivePins({32'h0, 32'h0000_0100, 32'h0000_0008});
    rd(8'h20, 32'h0000_0008, "R4");
    rd(8'h24, 32'h0000_0100, "R4");
    drivePins('0);

    // R5 rising capture on bank0 bit0
    wr(8'h50, 32'h1);
    drivePins(96'h1);
    rd(8'h90, 32'h1, "R5");
    chk("R9", {95'd0, irqOut}, 96'h1);
    wr(8'h90, 32'h1);
    rd(8'h90, 32'h0, "R8");
    drivePins('0);
    rd(8'h90, 32'h0, "R6 falling not enabled");

    // R6 falling capture on bank1 bit5
    wr(8'h64, 32'h20);
    drivePins(96'h1 << 37);
    rd(8'h94, 32'h0, "R6 rising not enabled");
    drivePins('0);
    rd(8'h94, 32'h20, "R6");

    // R7 both edges on bank2 bit7
    wr(8'h58, 32'h80);
    wr(8'h68, 32'h80);
    drivePins(96'h1 << 71);
    rd(8'h98, 32'h80, "R7");
    // R8 zero write leaves bit set
    wr(8'h98, 32'h0);
    rd(8'h98, 32'h80, "R8");

    // R8 capture beats clear in the same cycle
    @(posedge clk); #1;
    pinIn = '0;
    @(posedge clk); @(posedge clk); #1;
    busAddr = 8'h98; busWData = 32'h80; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
    rd(8'h98, 32'h80, "R8");

    // R9 irq drops only after every bank is clear
    wr(8'h98, 32'h80);
    rd(8'h98, 32'h0, "R7");
    chk("R9", {95'd0, irqOut}, 96'h1);
    wr(8'h94, 32'h20);
    chk("R9", {95'd0, irqOut}, 96'h0);

    repeat (3) @(posedge clk);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule